// File: doc/BRIEF.md
# Clock-Synchronous Serial Shift Port

A full-duplex, byte-wide synchronous serial port configured through four byte registers on a simple register bus. Each transfer moves eight bits out on a data-out pin and eight bits in from a data-in pin, against a transfer clock. The port generates that clock itself from a prescaled base clock and a reloading divider, or it follows a clock brought in on an input pin. A polarity bit picks which transfer-clock edge drives data and which edge samples it. A format bit picks least- or most-significant bit first.

A single handshake pin can work as a clear-to-send input, which holds back the start of a new byte, or as a ready-to-send output, which signals that a received byte has not yet been read. A disable bit turns the handshake off. Software loads a byte by writing the data register and polls a transmit-empty flag to learn when the byte has gone out. Reading the data register returns the last received byte and frees the receive buffer.

Register map (bus_addr): 0 = MODE, 1 = CTRL, 2 = DIV, 3 = DATA. MODE: bits 2:0 select the operating mode and bit 3 selects the external clock. CTRL: bits 1:0 select the count source, bit 2 selects the handshake role (0 = clear-to-send input, 1 = ready-to-send output), bit 3 is the read-only transmit-empty flag, bit 4 disables the handshake, bit 5 is the clock polarity and bit 6 selects most-significant-bit first. DIV holds the 8-bit divisor.

Top module: `sync_shift_port`

## Requirements
- R1: After reset MODE reads 0x00, CTRL reads 0x08, DIV reads 0x00, hs_out is 1 and sck_oe is 0.
- R2: Only MODE bits 2:0 = 001 enables the port. With any other value (000, 010, 011, 111 included), a DATA write is ignored: CTRL bit 3 stays 1 and sck_out does not toggle.
- R3: With the internal clock, sck_out toggles every (DIV+1)×N base-clock cycles during a transfer, where N is 1, 8 or 32 for CTRL bits 1:0 = 00, 01, 10. A transfer gives exactly 16 toggles.
- R4: With MODE bit 3 = 1, sck_oe is 0 and the byte is shifted on the edges of sck_in.
- R5: With polarity 0, the transfer clock idles high, sdo changes after falling edges and sdi is sampled on rising edges. With polarity 1 these edges are swapped and the clock idles low.
- R6: With CTRL bit 6 = 0, bit 0 is sent and received first. With CTRL bit 6 = 1, bit 7 goes first. The received byte reads back from DATA.
- R7: CTRL bit 3 reads 0 from an accepted DATA write until the eighth sample edge and 1 afterwards. A DATA write while a byte is pending is ignored.
- R8: With the handshake enabled as clear-to-send, hs_in = 1 prevents a new byte from starting, and a byte already shifting completes. With the handshake disabled, hs_in has no effect.
- R9: With the handshake enabled as ready-to-send, hs_out is 0 while the receive buffer is free and 1 once a received byte is unread. A DATA read frees the buffer. In every other handshake setting hs_out is 1.
- R10: A DATA read in the same cycle that a transfer completes leaves the receive buffer marked full.
- R11: Count-source code 11 produces no transfer clock, so a pending byte waits until a valid code is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect only on DATA) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| sck_in | input | 1 | External transfer clock |
| sck_out | output | 1 | Internal transfer clock |
| sck_oe | output | 1 | Drive enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| hs_in | input | 1 | Clear-to-send input, active low |
| hs_out | output | 1 | Ready-to-send output, active low |

## Verification
Two events can land on the same clock edge: the completion of a transfer, which marks the receive buffer full, and a software read of DATA, which frees it. The bench runs in ready-to-send mode with a half period of four cycles. It counts transfer-clock toggles at the pins, and after the fourteenth toggle it issues a single DATA read one cycle before, exactly on, and one cycle after the final sample edge. hs_out must then be 1, 1 and 0 for the three cases.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int FRAME_W    = 8;
    localparam int CNT_W      = $clog2(FRAME_W) + 1;
    localparam int DIV_W      = 8;
    localparam int MID_RATIO  = 8;
    localparam int SLOW_RATIO = 32;
    localparam int MID_W      = $clog2(MID_RATIO);
    localparam int PRE_W      = $clog2(SLOW_RATIO);
    localparam logic [2:0] MODE_SYNC = 3'b001;

    typedef enum logic [1:0] {
        A_MODE = 2'd0,
        A_CTRL = 2'd1,
        A_DIV  = 2'd2,
        A_DATA = 2'd3
    } addr_e;

    typedef enum logic [1:0] {
        SRC_F1  = 2'd0,
        SRC_F8  = 2'd1,
        SRC_F32 = 2'd2,
        SRC_OFF = 2'd3
    } src_e;

    typedef struct packed {
        logic [2:0]       mode;
        logic             ext;
        src_e             src;
        logic             hs_sel;
        logic             hs_off;
        logic             pol;
        logic             msb;
        logic [DIV_W-1:0] div;
    } cfg_t;
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
    import ssp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               hs_in,
    input  logic               busy,
    input  logic               done,
    input  logic [FRAME_W-1:0] rx_byte,
    output cfg_t               cfg,
    output logic [FRAME_W-1:0] tx_byte,
    output logic               start,
    output logic               tx_empty,
    output logic               rx_full,
    output logic               mode_ok,
    output logic               hs_out
);
    typedef struct packed {
        cfg_t               cfg;
        logic [FRAME_W-1:0] tx_buf;
        logic               pend;
        logic [FRAME_W-1:0] rx_buf;
        logic               full;
    } regs_t;

    regs_t s_d, s_q;
    logic  cts_ok;

    always_comb begin
        s_d     = s_q;
        mode_ok = (s_q.cfg.mode == MODE_SYNC);
        if (bus_wr) begin
            case (addr_e'(bus_addr))
                A_MODE: begin
                    s_d.cfg.mode = bus_wdata[2:0];
                    s_d.cfg.ext  = bus_wdata[3];
                end
                A_CTRL: begin
                    s_d.cfg.src    = src_e'(bus_wdata[1:0]);
                    s_d.cfg.hs_sel = bus_wdata[2];
                    s_d.cfg.hs_off = bus_wdata[4];
                    s_d.cfg.pol    = bus_wdata[5];
                    s_d.cfg.msb    = bus_wdata[6];
                end
                A_DIV: s_d.cfg.div = bus_wdata;
                default: begin
                    if (!s_q.pend && mode_ok) begin
                        s_d.tx_buf = bus_wdata;
                        s_d.pend   = 1'b1;
                    end
                end
            endcase
        end
        if (bus_rd && addr_e'(bus_addr) == A_DATA) s_d.full = 1'b0;
        if (done) begin
            s_d.pend   = 1'b0;
            s_d.rx_buf = rx_byte;
            s_d.full   = 1'b1;
        end
        if (!mode_ok) s_d.pend = 1'b0;

        cts_ok   = s_q.cfg.hs_off | s_q.cfg.hs_sel | ~hs_in;
        start    = s_q.pend & ~busy & mode_ok & cts_ok;
        tx_empty = ~s_q.pend;
        rx_full  = s_q.full;
        hs_out   = (!s_q.cfg.hs_off && s_q.cfg.hs_sel) ? s_q.full : 1'b1;
        cfg      = s_q.cfg;
        tx_byte  = s_q.tx_buf;

        case (addr_e'(bus_addr))
            A_MODE:  bus_rdata = {4'b0, s_q.cfg.ext, s_q.cfg.mode};
            A_CTRL:  bus_rdata = {1'b0, s_q.cfg.msb, s_q.cfg.pol, s_q.cfg.hs_off,
                                  ~s_q.pend, s_q.cfg.hs_sel, s_q.cfg.src};
            A_DIV:   bus_rdata = s_q.cfg.div;
            default: bus_rdata = s_q.rx_buf;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ssp_baud.sv
module ssp_baud
    import ssp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  src_e             src,
    input  logic [DIV_W-1:0] div,
    output logic             tog
);
    typedef struct packed {
        logic [PRE_W-1:0] pcnt;
        logic [DIV_W-1:0] bcnt;
    } baud_t;

    baud_t s_d, s_q;
    logic  tick;

    always_comb begin
        s_d = s_q;
        tog = 1'b0;
        case (src)
            SRC_F1:  tick = 1'b1;
            SRC_F8:  tick = (s_q.pcnt[MID_W-1:0] == {MID_W{1'b1}});
            SRC_F32: tick = (s_q.pcnt == {PRE_W{1'b1}});
            default: tick = 1'b0;
        endcase
        if (!run) begin
            s_d.pcnt = '0;
            s_d.bcnt = div;
        end else begin
            s_d.pcnt = s_q.pcnt + PRE_W'(1);
            if (tick) begin
                if (s_q.bcnt == '0) begin
                    s_d.bcnt = div;
                    tog      = 1'b1;
                end else begin
                    s_d.bcnt = s_q.bcnt - DIV_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine
    import ssp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_ok,
    input  logic               ext,
    input  logic               pol,
    input  logic               msb,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_byte,
    input  logic               tog,
    input  logic               sck_in,
    input  logic               sdi,
    output logic               busy,
    output logic               sck,
    output logic               sdo,
    output logic               done,
    output logic [FRAME_W-1:0] rx_byte
);
    typedef struct packed {
        logic               busy;
        logic               sck;
        logic               sdo;
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
        logic [CNT_W-1:0]   cnt;
        logic               s1;
        logic               s2;
    } eng_t;

    localparam eng_t RST = '{busy: 1'b0, sck: 1'b1, sdo: 1'b1, tx_sh: '0,
                             rx_sh: '0, cnt: '0, s1: 1'b1, s2: 1'b1};

    eng_t               s_d, s_q;
    logic               ev;
    logic               new_lvl;
    logic [FRAME_W-1:0] rx_nxt;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = sck_in;
        s_d.s2 = s_q.s1;
        done   = 1'b0;

        ev      = ext ? (s_q.s1 ^ s_q.s2) : tog;
        new_lvl = ext ? s_q.s1 : ~s_q.sck;
        rx_nxt  = msb ? {s_q.rx_sh[FRAME_W-2:0], sdi}
                      : {sdi, s_q.rx_sh[FRAME_W-1:1]};

        if (!mode_ok) begin
            s_d.busy = 1'b0;
            s_d.sck  = ~pol;
        end else if (!s_q.busy) begin
            s_d.sck = ~pol;
            if (start) begin
                s_d.busy  = 1'b1;
                s_d.tx_sh = tx_byte;
                s_d.cnt   = '0;
            end
        end else if (ev) begin
            if (!ext) s_d.sck = new_lvl;
            if (new_lvl == pol) begin
                if (msb) begin
                    s_d.sdo   = s_q.tx_sh[FRAME_W-1];
                    s_d.tx_sh = {s_q.tx_sh[FRAME_W-2:0], 1'b0};
                end else begin
                    s_d.sdo   = s_q.tx_sh[0];
                    s_d.tx_sh = {1'b0, s_q.tx_sh[FRAME_W-1:1]};
                end
            end else begin
                s_d.rx_sh = rx_nxt;
                s_d.cnt   = s_q.cnt + CNT_W'(1);
                if (s_q.cnt == CNT_W'(FRAME_W - 1)) begin
                    done     = 1'b1;
                    s_d.busy = 1'b0;
                end
            end
        end

        busy    = s_q.busy;
        sck     = s_q.sck;
        sdo     = s_q.sdo;
        rx_byte = rx_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       sck_in,
    output logic       sck_out,
    output logic       sck_oe,
    input  logic       sdi,
    output logic       sdo,
    input  logic       hs_in,
    output logic       hs_out
);
    cfg_t               cfg;
    logic [FRAME_W-1:0] tx_byte;
    logic [FRAME_W-1:0] rx_byte;
    logic               start;
    logic               tx_empty;
    logic               rx_full;
    logic               mode_ok;
    logic               busy;
    logic               done;
    logic               tog;

    ssp_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hs_in(hs_in), .busy(busy), .done(done), .rx_byte(rx_byte),
        .cfg(cfg), .tx_byte(tx_byte), .start(start),
        .tx_empty(tx_empty), .rx_full(rx_full), .mode_ok(mode_ok),
        .hs_out(hs_out)
    );

    ssp_baud u_baud (
        .clk(clk), .rst_n(rst_n),
        .run(busy & mode_ok & ~cfg.ext),
        .src(cfg.src), .div(cfg.div), .tog(tog)
    );

    ssp_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .mode_ok(mode_ok), .ext(cfg.ext), .pol(cfg.pol), .msb(cfg.msb),
        .start(start), .tx_byte(tx_byte), .tog(tog),
        .sck_in(sck_in), .sdi(sdi),
        .busy(busy), .sck(sck_out), .sdo(sdo), .done(done), .rx_byte(rx_byte)
    );

    assign sck_oe = mode_ok & ~cfg.ext;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_rd,
    input logic [2:0] mode,
    input logic       ext,
    input logic       pol,
    input logic       hs_sel,
    input logic       hs_off,
    input logic       hs_in,
    input logic       busy,
    input logic       done,
    input logic       tx_empty,
    input logic       rx_full,
    input logic       sck_out,
    input logic       sck_oe,
    input logic       sdo,
    input logic       hs_out
);
    // R7: a shifting byte always shows as not empty
    a_r7_busy_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_empty);

    // R2: a mode other than the synchronous one stops all shifting
    a_r2_halt_off_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'b001) |=> !busy);

    // R8: a high clear-to-send holds back a new byte
    a_r8_cts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hs_off && !hs_sel && hs_in) |=> !busy);

    // R9: ready-to-send only falls after a data read
    a_r9_rts_falls_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_off && hs_sel && $past(!hs_off && hs_sel) && $fell(hs_out))
        |-> $past(bus_rd && bus_addr == 2'd3));

    // R10: completion leaves the buffer full, whatever the bus does
    a_r10_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);

    // R5: with the internal clock, sdo moves only with a leading edge
    a_r5_drive_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 3'b001) && !ext && $past((mode == 3'b001) && !ext)
         && $stable(pol) && !$stable(sdo))
        |-> (!$stable(sck_out) && sck_out == pol));

    // R4: an external clock is never driven
    a_r4_ext_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ext |-> !sck_oe);
endmodule

bind sync_shift_port ssp_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .mode(cfg.mode), .ext(cfg.ext), .pol(cfg.pol),
    .hs_sel(cfg.hs_sel), .hs_off(cfg.hs_off), .hs_in(hs_in),
    .busy(busy), .done(done), .tx_empty(tx_empty), .rx_full(rx_full),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo(sdo), .hs_out(hs_out)
);

// File: tb/sim_sync_shift_port.sv
module sim_sync_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sck_in = 1'b1;
    logic       sck_out;
    logic       sck_oe;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       hs_in = 1'b1;
    logic       hs_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // pin monitor state
    logic       mon_pol = 1'b0;
    logic       mon_msb = 1'b0;
    logic [7:0] pat = '0;
    logic [7:0] cap = '0;
    logic       prv = 1'b1;
    int         ntog = 0;
    int         ntrail = 0;
    int         last = 0;
    int         dmin = 0;
    int         dmax = 0;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .hs_in(hs_in), .hs_out(hs_out)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (sck_out !== prv) begin
            ntog = ntog + 1;
            if (ntog > 1) begin
                if (cyc - last < dmin) dmin = cyc - last;
                if (cyc - last > dmax) dmax = cyc - last;
            end
            last = cyc;
            if (ntrail < 8) begin
                if (sck_out == mon_pol)
                    sdi = mon_msb ? pat[7 - ntrail] : pat[ntrail];
                else begin
                    cap[mon_msb ? 7 - ntrail : ntrail] = sdo;
                    ntrail = ntrail + 1;
                end
            end
        end
        prv = sck_out;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = (a == 2'd3);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic setup(input logic [2:0] m, input logic e, input logic [1:0] src,
                         input logic sel, input logic off, input logic p,
                         input logic msb, input logic [7:0] dv);
        wr(2'd2, dv);
        wr(2'd1, {1'b0, msb, p, off, 1'b0, sel, src});
        wr(2'd0, {4'b0, e, m});
    endtask

    task automatic mon_clear(input logic p, input logic msb, input logic [7:0] pt);
        @(negedge clk);
        #1;
        mon_pol = p; mon_msb = msb; pat = pt; cap = '0;
        ntog = 0; ntrail = 0; dmin = 1 << 30; dmax = 0;
    endtask

    task automatic wait_empty(input string tag);
        logic [7:0] v;
        int n;
        n = 0;
        v = '0;
        while (n < 20000 && !v[3]) begin
            peek(2'd1, v);
            n = n + 1;
        end
        if (!v[3]) check(tag, 32'(v[3]), 32'd1);
    endtask

    task automatic int_xfer(input logic p, input logic msb, input logic [1:0] src,
                            input logic [7:0] dv, input logic [7:0] tx, input logic [7:0] pt);
        logic [7:0] v;
        int half;
        half = (int'(dv) + 1) * (src == 2'd0 ? 1 : (src == 2'd1 ? 8 : 32));
        setup(3'b001, 1'b0, src, 1'b0, 1'b1, p, msb, dv);
        mon_clear(p, msb, pt);
        wr(2'd3, tx);
        wait_empty("R7 completion");
        repeat (3) @(negedge clk);
        check("R5 R6 sent byte", 32'(cap), 32'(tx));
        rd(2'd3, v);
        check("R6 received byte", 32'(v), 32'(pt));
        check("R3 toggle count", 32'(ntog), 32'd16);
        check("R3 half period min", 32'(dmin), 32'(half));
        check("R3 half period max", 32'(dmax), 32'(half));
    endtask

    task automatic ext_xfer(input logic p, input logic msb, input logic [7:0] tx, input logic [7:0] pt);
        logic [7:0] c;
        logic [7:0] v;
        sck_in = ~p;
        setup(3'b001, 1'b1, 2'd0, 1'b0, 1'b1, p, msb, 8'd0);
        repeat (5) @(negedge clk);
        check("R4 sck_oe low with external clock", 32'(sck_oe), 32'd0);
        wr(2'd3, tx);
        repeat (4) @(negedge clk);
        c = '0;
        for (int k = 0; k < 8; k++) begin
            sck_in = p;
            sdi = msb ? pt[7 - k] : pt[k];
            repeat (6) @(negedge clk);
            c[msb ? 7 - k : k] = sdo;
            sck_in = ~p;
            repeat (6) @(negedge clk);
        end
        wait_empty("R4 completion");
        check("R4 R6 sent byte external", 32'(c), 32'(tx));
        rd(2'd3, v);
        check("R4 R6 received byte external", 32'(v), 32'(pt));
    endtask

    initial begin
        logic [7:0] v;
        int idx;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(2'd0, v); check("R1 MODE reset", 32'(v), 32'h00);
        peek(2'd1, v); check("R1 CTRL reset", 32'(v), 32'h08);
        peek(2'd2, v); check("R1 DIV reset", 32'(v), 32'h00);
        check("R1 hs_out reset", 32'(hs_out), 32'd1);
        check("R1 sck_oe reset", 32'(sck_oe), 32'd0);

        // R2 non-synchronous modes ignore data
        for (int i = 0; i < 4; i++) begin
            logic [2:0] m;
            m = (i == 0) ? 3'b000 : (i == 1) ? 3'b010 : (i == 2) ? 3'b011 : 3'b111;
            setup(m, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0);
            mon_clear(1'b0, 1'b0, 8'h00);
            wr(2'd3, 8'h5A);
            repeat (60) @(negedge clk);
            peek(2'd1, v);
            check("R2 empty stays 1 in other mode", 32'(v[3]), 32'd1);
            check("R2 no clock in other mode", 32'(ntog), 32'd0);
        end

        // R3 R5 R6 sweep: polarity x order x rate; hs_in high, handshake off (R8)
        idx = 0;
        for (int p = 0; p < 2; p++)
            for (int o = 0; o < 2; o++)
                for (int r = 0; r < 4; r++) begin
                    logic [1:0] src;
                    logic [7:0] dv;
                    src = (r == 2) ? 2'd1 : (r == 3) ? 2'd2 : 2'd0;
                    dv  = (r == 1) ? 8'd3 : (r == 2) ? 8'd1 : 8'd0;
                    int_xfer(p[0], o[0], src, dv, 8'hA5 ^ 8'(idx * 37), 8'h3C + 8'(idx * 11));
                    idx = idx + 1;
                end

        // R4 external clock
        for (int p = 0; p < 2; p++)
            for (int o = 0; o < 2; o++)
                ext_xfer(p[0], o[0], 8'hC3 ^ 8'(p * 16 + o), 8'h1E + 8'(p * 64 + o * 3));
        sck_in = 1'b1;

        // R7 empty flag and write while pending
        setup(3'b001, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd2);
        mon_clear(1'b0, 1'b0, 8'h00);
        wr(2'd3, 8'h96);
        peek(2'd1, v);
        check("R7 empty low after write", 32'(v[3]), 32'd0);
        wr(2'd3, 8'h0F);
        wait_empty("R7 completion");
        repeat (50) @(negedge clk);
        check("R7 first byte kept", 32'(cap), 32'h96);
        check("R7 second write ignored", 32'(ntog), 32'd16);

        // R11 reserved count source
        setup(3'b001, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0);
        mon_clear(1'b0, 1'b0, 8'h44);
        wr(2'd3, 8'h6D);
        repeat (200) @(negedge clk);
        peek(2'd1, v);
        check("R11 byte still pending", 32'(v[3]), 32'd0);
        check("R11 no clock on reserved source", 32'(ntog), 32'd0);
        wr(2'd1, 8'h10);
        wait_empty("R11 completion");
        repeat (3) @(negedge clk);
        check("R11 byte sent after valid source", 32'(cap), 32'h6D);
        rd(2'd3, v);

        // R8 clear-to-send gating
        setup(3'b001, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3);
        hs_in = 1'b1;
        mon_clear(1'b0, 1'b0, 8'h81);
        wr(2'd3, 8'hB2);
        repeat (100) @(negedge clk);
        check("R8 no start while hs_in high", 32'(ntog), 32'd0);
        hs_in = 1'b0;
        while (ntog < 4) @(negedge clk);
        hs_in = 1'b1;
        wait_empty("R8 completion");
        repeat (3) @(negedge clk);
        check("R8 byte in progress completes", 32'(cap), 32'hB2);
        check("R8 toggle count", 32'(ntog), 32'd16);
        rd(2'd3, v);
        check("R8 received byte", 32'(v), 32'h81);

        // R9 ready-to-send
        setup(3'b001, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd2);
        rd(2'd3, v);
        check("R9 hs_out low while free", 32'(hs_out), 32'd0);
        mon_clear(1'b0, 1'b1, 8'h5C);
        wr(2'd3, 8'h27);
        wait_empty("R9 completion");
        @(negedge clk);
        check("R9 hs_out high when unread", 32'(hs_out), 32'd1);
        rd(2'd3, v);
        check("R9 data", 32'(v), 32'h5C);
        check("R9 hs_out low after read", 32'(hs_out), 32'd0);
        mon_clear(1'b0, 1'b1, 8'h11);
        wr(2'd3, 8'h22);
        wait_empty("R9 completion 2");
        wr(2'd1, 8'h54);
        @(negedge clk);
        check("R9 hs_out high when handshake off", 32'(hs_out), 32'd1);

        // R10 read strobe against completion: before, same cycle, after
        for (int k = 6; k < 9; k++) begin
            int n;
            setup(3'b001, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd3);
            mon_clear(1'b0, 1'b0, 8'h70 + 8'(k));
            wr(2'd3, 8'hE1);
            n = 0;
            while (ntog < 14 && n < 5000) begin
                @(negedge clk); #1; n = n + 1;
            end
            repeat (k) @(negedge clk);
            bus_addr = 2'd3; bus_rd = 1'b1;
            @(negedge clk);
            bus_rd = 1'b0;
            wait_empty("R10 completion");
            @(negedge clk);
            check("R10 full after read vs completion", 32'(hs_out), (k < 8) ? 32'd1 : 32'd0);
            rd(2'd3, v);
            check("R10 new byte stored", 32'(v), 32'(8'h70 + 8'(k)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule